// File: doc/BRIEF.md
# Partial-Write Read-Modify-Write Sequencer

This block sits between a requester and a memory that only ever transfers whole 16-byte units. A request names one unit, carries a byte mask and, for writes, a full unit of data, so it may touch anywhere from one byte to the whole unit. Every request becomes one or more whole-unit memory commands, and a single byte costs the same slot as sixteen.

A runtime `ecc_en` input chooses between two write policies. With protection off, every write goes out as one masked unit write. With protection on, a write that enables at least `RMW_MIN_BYTES` bytes still goes out as one write. A narrower write becomes a two-slot sequence instead: the unit is read, the new bytes are merged into the returned data, and the result is written back whole. Check bits are made by a simple per-byte parity generator that stands in for a real code. Reads return the whole unit, and the bytes outside the mask carry no meaning. Reads taken with protection on report a check mismatch.

Top module: `rmw_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_cmd_valid` is 0 and `rsp_valid` is 0.
- R2: An accepted read issues exactly one unit read command (`mem_cmd_write`=0, all mask bits set) for `req_addr`. One cycle after `mem_rsp_valid`, `rsp_valid` pulses with `rsp_rdata` equal to the returned unit.
- R3: With `ecc_en`=0, an accepted write issues exactly one write command carrying the request mask and data, and no read.
- R4: With `ecc_en`=1 and at least `RMW_MIN_BYTES` (8) mask bits set, an accepted write issues exactly one write with the request mask and no read. In every write command, bit i of `mem_cmd_check` is the XOR of the eight bits of byte i of `mem_cmd_wdata`, where byte i is bits 8i+7..8i.
- R5: With `ecc_en`=1 and fewer than 8 mask bits set (a mask of zero included), an accepted write issues exactly two commands: a unit read first, then a write with all 16 mask bits set.
- R6: In the write-back of R5, byte i comes from the request when mask bit i is 1 and from the read data when it is 0.
- R7: `req_ready` is 0 from the cycle after acceptance until the last command of the request is taken, and for reads until `rsp_valid` has been raised. A request held valid during that time is accepted only once.
- R8: On a read accepted with `ecc_en`=1, `rsp_err` is 1 exactly when some returned check bit differs from the parity of its data byte. On a read accepted with `ecc_en`=0, `rsp_err` is 0.
- R9: While `mem_cmd_valid` is 1 and `mem_cmd_ready` is 0, the command's type, address, mask and data hold unchanged on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ecc_en | input | 1 | Protection enable, sampled when a request is accepted |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Unit address |
| req_mask | input | UNIT_BYTES | Byte enables |
| req_wdata | input | UNIT_BYTES*8 | Write data, byte i at bits 8i+7..8i |
| rsp_valid | output | 1 | Read data pulse |
| rsp_rdata | output | UNIT_BYTES*8 | Read unit |
| rsp_err | output | 1 | Check mismatch on the read |
| mem_cmd_valid | output | 1 | Memory command present |
| mem_cmd_ready | input | 1 | Memory takes the command |
| mem_cmd_write | output | 1 | 1 = unit write, 0 = unit read |
| mem_cmd_addr | output | ADDR_W | Unit address |
| mem_cmd_mask | output | UNIT_BYTES | Byte enables of the write |
| mem_cmd_wdata | output | UNIT_BYTES*8 | Write data |
| mem_cmd_check | output | UNIT_BYTES | Check bits of the write data |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_rdata | input | UNIT_BYTES*8 | Returned unit |
| mem_rsp_check | input | UNIT_BYTES | Returned check bits |

## Verification
The assertions take for granted that the memory returns exactly one `mem_rsp_valid` pulse for each read command it takes, and never raises that pulse while no read is outstanding. They also assume `ecc_en` and the request fields are steady in the cycle a request is accepted. The bench memory model keeps to this by answering each taken read in the following cycle. The bench drives requests only at falling edges, and during stalls it toggles `mem_cmd_ready` on a fixed pattern, so a command is never taken twice.

// File: rtl/rmw_sequencer.sv
module rmw_sequencer #(
  parameter int UNIT_BYTES    = 16,
  parameter int ADDR_W        = 28,
  parameter int RMW_MIN_BYTES = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ecc_en,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic                    req_write,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [UNIT_BYTES-1:0]   req_mask,
  input  logic [UNIT_BYTES*8-1:0] req_wdata,
  output logic                    rsp_valid,
  output logic [UNIT_BYTES*8-1:0] rsp_rdata,
  output logic                    rsp_err,
  output logic                    mem_cmd_valid,
  input  logic                    mem_cmd_ready,
  output logic                    mem_cmd_write,
  output logic [ADDR_W-1:0]       mem_cmd_addr,
  output logic [UNIT_BYTES-1:0]   mem_cmd_mask,
  output logic [UNIT_BYTES*8-1:0] mem_cmd_wdata,
  output logic [UNIT_BYTES-1:0]   mem_cmd_check,
  input  logic                    mem_rsp_valid,
  input  logic [UNIT_BYTES*8-1:0] mem_rsp_rdata,
  input  logic [UNIT_BYTES-1:0]   mem_rsp_check
);

  localparam int DW = UNIT_BYTES * 8;
  localparam int CW = $clog2(UNIT_BYTES + 1);

  typedef enum logic [2:0] {
    S_IDLE, S_RD, S_RD_WAIT, S_WR, S_RMW_RD, S_RMW_WAIT, S_RMW_WR
  } state_t;

  state_t                state;
  logic                  h_ecc;
  logic [ADDR_W-1:0]     h_addr;
  logic [UNIT_BYTES-1:0] h_mask;
  logic [DW-1:0]         h_data;
  logic [CW-1:0]         req_cnt;
  logic [DW-1:0]         merged;
  logic [UNIT_BYTES-1:0] rsp_par;
  logic                  accept, narrow, cmd_take;

  always_comb begin
    req_cnt = '0;
    for (int i = 0; i < UNIT_BYTES; i++) req_cnt = req_cnt + CW'(req_mask[i]);
  end

  for (genvar b = 0; b < UNIT_BYTES; b++) begin : g_byte
    assign merged[b*8 +: 8]     = h_mask[b] ? h_data[b*8 +: 8] : mem_rsp_rdata[b*8 +: 8];
    assign rsp_par[b]           = ^mem_rsp_rdata[b*8 +: 8];
    assign mem_cmd_check[b]     = ^mem_cmd_wdata[b*8 +: 8];
  end

  assign req_ready     = (state == S_IDLE);
  assign accept        = req_valid && req_ready;
  assign narrow        = req_cnt < CW'(RMW_MIN_BYTES);
  assign mem_cmd_valid = (state == S_RD) || (state == S_WR) ||
                         (state == S_RMW_RD) || (state == S_RMW_WR);
  assign mem_cmd_write = (state == S_WR) || (state == S_RMW_WR);
  assign mem_cmd_addr  = h_addr;
  assign mem_cmd_mask  = (state == S_WR) ? h_mask : '1;
  assign mem_cmd_wdata = h_data;
  assign cmd_take      = mem_cmd_valid && mem_cmd_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      h_ecc     <= 1'b0;
      h_addr    <= '0;
      h_mask    <= '0;
      h_data    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        S_IDLE: if (accept) begin
          h_ecc  <= ecc_en;
          h_addr <= req_addr;
          h_mask <= req_mask;
          h_data <= req_wdata;
          if (!req_write)               state <= S_RD;
          else if (ecc_en && narrow)    state <= S_RMW_RD;
          else                          state <= S_WR;
        end
        S_RD:       if (cmd_take) state <= S_RD_WAIT;
        S_RD_WAIT:  if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_rdata <= mem_rsp_rdata;
          rsp_err   <= h_ecc && (rsp_par != mem_rsp_check);
          state     <= S_IDLE;
        end
        S_WR:       if (cmd_take) state <= S_IDLE;
        S_RMW_RD:   if (cmd_take) state <= S_RMW_WAIT;
        S_RMW_WAIT: if (mem_rsp_valid) begin
          h_data <= merged;
          state  <= S_RMW_WR;
        end
        S_RMW_WR:   if (cmd_take) state <= S_IDLE;
        default:    state <= S_IDLE;
      endcase
    end
  end

  p_read_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !req_write |=> mem_cmd_valid && !mem_cmd_write && (&mem_cmd_mask) &&
                             mem_cmd_addr == $past(req_addr));

  p_rsp_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(mem_rsp_valid));

  p_plain_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && !ecc_en |=> mem_cmd_valid && mem_cmd_write &&
                                       mem_cmd_mask == $past(req_mask));

  p_wide_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && ecc_en && ($countones(req_mask) >= RMW_MIN_BYTES)
      |=> mem_cmd_valid && mem_cmd_write && mem_cmd_mask == $past(req_mask));

  p_rmw_read_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    accept && req_write && ecc_en && ($countones(req_mask) < RMW_MIN_BYTES)
      |=> mem_cmd_valid && !mem_cmd_write);

  p_rmw_writeback_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RMW_WAIT) && mem_rsp_valid |=> mem_cmd_valid && mem_cmd_write && (&mem_cmd_mask));

  p_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> !req_ready);

  p_cmd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid && !mem_cmd_ready |=> mem_cmd_valid && $stable(mem_cmd_write) &&
      $stable(mem_cmd_addr) && $stable(mem_cmd_mask) && $stable(mem_cmd_wdata));

endmodule

// File: tb/tb_rmw_sequencer.sv
module tb_rmw_sequencer;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic         rst_n, ecc_en, req_valid, req_ready, req_write;
  logic [27:0]  req_addr;
  logic [15:0]  req_mask;
  logic [127:0] req_wdata;
  logic         rsp_valid, rsp_err;
  logic [127:0] rsp_rdata;
  logic         mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [27:0]  mem_cmd_addr;
  logic [15:0]  mem_cmd_mask, mem_cmd_check;
  logic [127:0] mem_cmd_wdata;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_rdata;
  logic [15:0]  mem_rsp_check;

  rmw_sequencer dut (.*);

  // memory model, answers each taken read in the next cycle
  logic [127:0] mdat [16];
  logic [15:0]  mchk [16];
  logic [127:0] flip;
  logic         stall_en;
  logic         cyc;
  int rd_cnt, wr_cnt, rsp_cnt, acc_cnt, bad_chk;
  logic [127:0] last_rsp;
  logic         last_err;

  assign mem_cmd_ready = !stall_en || cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int u = 0; u < 16; u++) begin mdat[u] <= '0; mchk[u] <= '0; end
      mem_rsp_valid <= 1'b0; mem_rsp_rdata <= '0; mem_rsp_check <= '0;
      rd_cnt <= 0; wr_cnt <= 0; rsp_cnt <= 0; acc_cnt <= 0; bad_chk <= 0; cyc <= 1'b0;
      last_rsp <= '0; last_err <= 1'b0;
    end else begin
      cyc <= !cyc;
      mem_rsp_valid <= 1'b0;
      if (req_valid && req_ready) acc_cnt <= acc_cnt + 1;
      if (rsp_valid) begin rsp_cnt <= rsp_cnt + 1; last_rsp <= rsp_rdata; last_err <= rsp_err; end
      if (mem_cmd_valid && mem_cmd_ready) begin
        if (mem_cmd_write) begin
          wr_cnt <= wr_cnt + 1;
          for (int b = 0; b < 16; b++) if (mem_cmd_mask[b]) begin
            mdat[mem_cmd_addr[3:0]][b*8 +: 8] <= mem_cmd_wdata[b*8 +: 8];
            mchk[mem_cmd_addr[3:0]][b]        <= mem_cmd_check[b];
            if (mem_cmd_check[b] != ^mem_cmd_wdata[b*8 +: 8]) bad_chk <= bad_chk + 1;
          end
        end else begin
          rd_cnt        <= rd_cnt + 1;
          mem_rsp_valid <= 1'b1;
          mem_rsp_rdata <= mdat[mem_cmd_addr[3:0]] ^ flip;
          mem_rsp_check <= mchk[mem_cmd_addr[3:0]];
        end
      end
    end
  end

  int vectors = 0, miscompares = 0;
  logic [127:0] shadow [16];

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] gen(input int i);
    logic [127:0] d;
    for (int b = 0; b < 16; b++) d[b*8 +: 8] = 8'(i * 29 + b * 7 + 3);
    return d;
  endfunction

  function automatic logic [127:0] bytemask(input logic [15:0] m);
    logic [127:0] r;
    for (int b = 0; b < 16; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  // run one request; returns read and write command counts it caused
  task automatic run_req(input logic wr, input logic ecc, input logic [3:0] u,
                         input logic [15:0] m, input logic [127:0] d,
                         output int nrd, output int nwr);
    int r0, w0, s0, n;
    n = 0;
    @(negedge clk);
    while (!req_ready && n < 1000) begin @(negedge clk); n++; end
    r0 = rd_cnt; w0 = wr_cnt; s0 = rsp_cnt;
    req_valid = 1'b1; req_write = wr; ecc_en = ecc;
    req_addr = {24'd0, u}; req_mask = m; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!(req_ready && (wr || rsp_cnt > s0)) && n < 1000) begin @(negedge clk); n++; end
    if (n >= 1000) chk("watchdog", 128'd1, 128'd0);
    nrd = rd_cnt - r0; nwr = wr_cnt - w0;
    if (wr) for (int b = 0; b < 16; b++) if (m[b]) shadow[u][b*8 +: 8] = d[b*8 +: 8];
  endtask

  // {write, ecc, unit[3:0], mask[15:0], exp reads[1:0], exp writes[1:0]}
  localparam int NV = 13;
  localparam logic [25:0] VEC [NV] = '{
    {1'b1, 1'b0, 4'd0, 16'hFFFF, 2'd0, 2'd1},  // R3
    {1'b1, 1'b0, 4'd1, 16'hFFFF, 2'd0, 2'd1},  // R3
    {1'b1, 1'b1, 4'd2, 16'hFFFF, 2'd0, 2'd1},  // R4 full
    {1'b1, 1'b0, 4'd0, 16'h0001, 2'd0, 2'd1},  // R3 single byte
    {1'b1, 1'b1, 4'd1, 16'h0001, 2'd1, 2'd1},  // R5/R6 single byte
    {1'b1, 1'b1, 4'd1, 16'h007F, 2'd1, 2'd1},  // R5 seven bytes
    {1'b1, 1'b1, 4'd2, 16'h00FF, 2'd0, 2'd1},  // R4 eight bytes
    {1'b1, 1'b1, 4'd2, 16'hF0F0, 2'd0, 2'd1},  // R4 scattered eight
    {1'b0, 1'b1, 4'd1, 16'hFFFF, 2'd1, 2'd0},  // R2
    {1'b0, 1'b0, 4'd0, 16'h000F, 2'd1, 2'd0},  // R2
    {1'b1, 1'b1, 4'd0, 16'h8000, 2'd1, 2'd1},  // R5/R6 top byte
    {1'b0, 1'b1, 4'd2, 16'h0100, 2'd1, 2'd0},  // R2/R8 clean read
    {1'b1, 1'b1, 4'd3, 16'h0000, 2'd1, 2'd1}   // R5 empty mask
  };

  initial begin
    int nrd, nwr, a0;
    logic [25:0] v;
    rst_n = 1'b0; ecc_en = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_mask = '0; req_wdata = '0; flip = '0; stall_en = 1'b0;
    for (int u = 0; u < 16; u++) shadow[u] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 req_ready", 128'(req_ready), 128'd1);
    chk("R1 mem_cmd_valid", 128'(mem_cmd_valid), 128'd0);
    chk("R1 rsp_valid", 128'(rsp_valid), 128'd0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      run_req(v[25], v[24], v[23:20], v[19:4], gen(i), nrd, nwr);
      chk($sformatf("R2-5 vec%0d reads", i), 128'(nrd), 128'(v[3:2]));
      chk($sformatf("R2-5 vec%0d writes", i), 128'(nwr), 128'(v[1:0]));
      if (v[25]) chk($sformatf("R6 vec%0d unit", i), mdat[v[23:20]], shadow[v[23:20]]);
      else begin
        chk($sformatf("R2 vec%0d data", i), last_rsp & bytemask(v[19:4]),
            shadow[v[23:20]] & bytemask(v[19:4]));
        chk($sformatf("R8 vec%0d err", i), 128'(last_err), 128'd0);
      end
    end
    chk("R4 check bits", 128'(bad_chk), 128'd0);

    // R8: corrupted return with protection on and off
    flip = 128'h1 << 40;
    run_req(1'b0, 1'b1, 4'd1, 16'hFFFF, '0, nrd, nwr);
    chk("R8 err on", 128'(last_err), 128'd1);
    chk("R8 data", last_rsp, shadow[1] ^ flip);
    run_req(1'b0, 1'b0, 4'd1, 16'hFFFF, '0, nrd, nwr);
    chk("R8 err off", 128'(last_err), 128'd0);
    flip = '0;

    // R7: request held valid across a read-modify-write is taken once
    @(negedge clk);
    a0 = acc_cnt;
    req_valid = 1'b1; req_write = 1'b1; ecc_en = 1'b1;
    req_addr = 28'd5; req_mask = 16'h0010; req_wdata = gen(40);
    repeat (4) @(negedge clk);
    req_valid = 1'b0;
    for (int b = 0; b < 16; b++) if (req_mask[b]) shadow[5][b*8 +: 8] = req_wdata[b*8 +: 8];
    chk("R7 single accept", 128'(acc_cnt - a0), 128'd1);
    chk("R7 ready after writeback", 128'(req_ready), 128'd1);
    chk("R6 held request unit", mdat[5], shadow[5]);

    // R9: stalled command port
    stall_en = 1'b1;
    run_req(1'b1, 1'b1, 4'd5, 16'h0300, gen(41), nrd, nwr);
    chk("R9 stall rmw reads", 128'(nrd), 128'd1);
    chk("R9 stall rmw writes", 128'(nwr), 128'd1);
    chk("R9 stall rmw unit", mdat[5], shadow[5]);
    run_req(1'b0, 1'b1, 4'd5, 16'hFFFF, '0, nrd, nwr);
    chk("R9 stall read", last_rsp, shadow[5]);
    stall_en = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule